// File: doc/BRIEF.md
# Serial Slave Hold Gating

This block sits between the pins of a serial memory slave and its internal command shifter. It watches the pause pin, the serial clock and the select pin, and decides when the interface is paused. While the interface is paused, the shifter receives no clock qualifiers, its state stays as it was, and the data output driver is switched off. A pause can only begin while the slave is selected.

Pause entry and pause exit line up with the low phase of the serial clock. If the pause pin changes while the serial clock is high, the change waits until the clock next goes low. If the slave is deselected during a pause, the interface is reset. It then stays reset until the pause pin has been seen released. This stops the slave from dropping straight back into a pause when it is selected again.

All pins are sampled in the system clock domain through a synchronizer of `SYNC_STAGES` flops. Every output is registered. A pin change therefore shows at the outputs `SYNC_STAGES + 1` system clock cycles later. The internal busy flag of a running write, program or erase cycle is passed through and is never touched by a pause.

Top module: `hold_gate`

## Requirements
- R1: While reset is asserted, and right after it, held_o=0, dout_oe_o=0, intf_rst_o=1, shift_rise_o=0, shift_fall_o=0 and busy_o=0.
- R2: A change on sclk_i, cs_n_i or hold_n_i reaches held_o, dout_oe_o and intf_rst_o exactly SYNC_STAGES+1 system clock cycles later (3 with the default SYNC_STAGES=2).
- R3: When hold_n_i falls to 0 while cs_n_i=0 and sclk_i=0, held_o becomes 1 and dout_oe_o becomes 0 straight away.
- R4: When hold_n_i falls to 0 while sclk_i=1, held_o stays 0 and dout_oe_o stays 1. Both change only once sclk_i goes to 0.
- R5: When hold_n_i rises to 1 while sclk_i=0, held_o returns to 0 straight away. When it rises while sclk_i=1, held_o stays 1 until sclk_i goes to 0.
- R6: If hold_n_i returns to 1 before a pending entry has taken effect, the pause is cancelled. held_o stays 0 and dout_oe_o stays 1.
- R7: Each sclk_i rising edge while the interface is running gives exactly one one-cycle shift_rise_o pulse. Each falling edge gives exactly one one-cycle shift_fall_o pulse. While held, no edge gives a pulse. The falling edge that starts a pause gives no pulse, and neither does the falling edge that ends one.
- R8: dout_oe_o is 1 only while cs_n_i=0, the interface is not held and the interface is not locked out. Otherwise it is 0.
- R9: If cs_n_i rises to 1 while held, intf_rst_o becomes 1 and a lockout starts. The lockout lasts until hold_n_i is seen at 1. During the lockout, intf_rst_o=1, dout_oe_o=0 and held_o=0, even after cs_n_i goes back to 0.
- R10: busy_o equals busy_i delayed by one system clock cycle, whatever the pause or select state.
- R11: hold_n_i=0 while cs_n_i=1 never sets held_o and never starts a lockout. intf_rst_o is 1 because of the deselect alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Select pin, active low |
| hold_n_i | input | 1 | Pause pin, active low |
| busy_i | input | 1 | Busy flag of a running write, program or erase cycle |
| held_o | output | 1 | Interface is paused |
| dout_oe_o | output | 1 | Output enable for the serial data pin |
| shift_rise_o | output | 1 | One-cycle qualifier for a serial clock rising edge to the shifter |
| shift_fall_o | output | 1 | One-cycle qualifier for a serial clock falling edge to the shifter |
| intf_rst_o | output | 1 | Reset request for the shifter and sequencer |
| busy_o | output | 1 | Busy flag passed through, unaffected by pauses |

## Verification
A table of pin patterns steps the pause pin through both phases of the serial clock. This shows apart an immediate entry or exit (clock low), a deferred one (clock high), and a pending entry cancelled before the clock falls. Patterns where select and pause change together separate a deselect-during-pause from a plain deselect. This is the difference between a lockout and no lockout. A clock burst runs across a deferred entry, several held pulses and a deferred exit. Counting the shift pulses shows that only running edges get through. A single-cycle sampling test checks the exact pin-to-output latency, and a busy toggle during a pause and a deselect shows that the busy flag is untouched.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;

  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_ENTER_WAIT = 2'd1,
    ST_HELD       = 2'd2,
    ST_EXIT_WAIT  = 2'd3
  } hold_state_e;

  localparam int unsigned PIN_COUNT = 3;
  localparam int unsigned PIN_SCLK  = 0;
  localparam int unsigned PIN_CSN   = 1;
  localparam int unsigned PIN_HOLDN = 2;

endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_in;
    if (s == 0) begin : g_first
      assign stage_in = d_i;
    end else begin : g_next
      assign stage_in = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_in;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  input  logic hold_n_s,
  output logic held_o,
  output logic dout_oe_o,
  output logic shift_rise_o,
  output logic shift_fall_o,
  output logic intf_rst_o
);

  hold_state_e state_q, state_d;
  logic lock_q, lock_d;
  logic sclk_q;
  logic run_q, run_d;
  logic held_d, rise_d, fall_d, irst_d;
  logic sel, hold_req, held_cur, sclk_rise, sclk_fall;

  always_comb begin
    sel       = !cs_n_s;
    hold_req  = !hold_n_s;
    held_cur  = (state_q == ST_HELD) || (state_q == ST_EXIT_WAIT);
    sclk_rise = sclk_s && !sclk_q;
    sclk_fall = !sclk_s && sclk_q;
    lock_d    = (cs_n_s && held_cur) || (lock_q && hold_req);
    state_d   = state_q;
    if (!sel || lock_d) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (hold_req) state_d = sclk_s ? ST_ENTER_WAIT : ST_HELD;
        end
        ST_ENTER_WAIT: begin
          if (!hold_req)   state_d = ST_RUN;
          else if (!sclk_s) state_d = ST_HELD;
        end
        ST_HELD: begin
          if (!hold_req) state_d = sclk_s ? ST_EXIT_WAIT : ST_RUN;
        end
        ST_EXIT_WAIT: begin
          if (hold_req)    state_d = ST_HELD;
          else if (!sclk_s) state_d = ST_RUN;
        end
        default: state_d = ST_RUN;
      endcase
    end
    held_d = (state_d == ST_HELD) || (state_d == ST_EXIT_WAIT);
    run_d  = sel && !lock_d && !held_d;
    rise_d = sclk_rise && run_q && run_d;
    fall_d = sclk_fall && run_q && run_d;
    irst_d = !sel || lock_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_RUN;
      lock_q       <= 1'b0;
      sclk_q       <= 1'b0;
      run_q        <= 1'b0;
      held_o       <= 1'b0;
      shift_rise_o <= 1'b0;
      shift_fall_o <= 1'b0;
      intf_rst_o   <= 1'b1;
    end else begin
      state_q      <= state_d;
      lock_q       <= lock_d;
      sclk_q       <= sclk_s;
      run_q        <= run_d;
      held_o       <= held_d;
      shift_rise_o <= rise_d;
      shift_fall_o <= fall_d;
      intf_rst_o   <= irst_d;
    end
  end

  assign dout_oe_o = run_q;

  // R3
  entry_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !cs_n_s && !lock_q && !hold_n_s && !sclk_s) |=> held_o);

  // R7
  no_shift_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_o |-> (!shift_rise_o && !shift_fall_o));

  // R8
  oe_off_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o || intf_rst_o) |-> !dout_oe_o);

  // R9
  deselect_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_cur && cs_n_s) |=> (intf_rst_o && !dout_oe_o && !held_o));

  // R9
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !hold_n_s) |=> (!dout_oe_o && !held_o && intf_rst_o));

endmodule

// File: rtl/hold_gate.sv
module hold_gate
  import hold_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic hold_n_i,
  input  logic busy_i,
  output logic held_o,
  output logic dout_oe_o,
  output logic shift_rise_o,
  output logic shift_fall_o,
  output logic intf_rst_o,
  output logic busy_o
);

  localparam logic [PIN_COUNT-1:0] PIN_RST = 3'b110;

  logic                 rst_int_n;
  logic [PIN_COUNT-1:0] pins_raw, pins_s;

  hold_pin_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_int_n)
  );

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_SCLK]  = sclk_i;
    pins_raw[PIN_CSN]   = cs_n_i;
    pins_raw[PIN_HOLDN] = hold_n_i;
  end

  hold_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) pin_sync_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  hold_fsm fsm_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sclk_s       (pins_s[PIN_SCLK]),
    .cs_n_s       (pins_s[PIN_CSN]),
    .hold_n_s     (pins_s[PIN_HOLDN]),
    .held_o       (held_o),
    .dout_oe_o    (dout_oe_o),
    .shift_rise_o (shift_rise_o),
    .shift_fall_o (shift_fall_o),
    .intf_rst_o   (intf_rst_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) busy_o <= 1'b0;
    else            busy_o <= busy_i;
  end

  // R10
  busy_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) |-> (busy_o == $past(busy_i)));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(shift_rise_o && shift_fall_o));

endmodule

// File: tb/hold_gate_tb_top.sv
module hold_gate_tb_top;

  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;
  localparam int NVEC = 20;
  // {cs_n, hold_n, sclk, exp_held, exp_oe, exp_rst}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110_001, 6'b010_010, 6'b011_010, 6'b001_010, 6'b000_100,
    6'b001_100, 6'b011_100, 6'b010_010, 6'b000_100, 6'b010_010,
    6'b001_010, 6'b011_010, 6'b000_100, 6'b100_001, 6'b000_001,
    6'b010_010, 6'b100_001, 6'b110_001, 6'b010_010, 6'b110_001
  };

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, hold_n, busy;
  logic held, oe, srise, sfall, irst, busy_o;
  int checks = 0, failures = 0;
  int rise_cnt = 0, fall_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hold_gate #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .busy_i(busy), .held_o(held), .dout_oe_o(oe), .shift_rise_o(srise),
    .shift_fall_o(sfall), .intf_rst_o(irst), .busy_o(busy_o)
  );

  always @(negedge clk) begin
    if (srise) rise_cnt++;
    if (sfall) fall_cnt++;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic c, logic h, logic s);
    cs_n = c; hold_n = h; sclk = s;
    settle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; hold_n = 1'b1; sclk = 1'b0; busy = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 held", held, 0);
    check("R1 oe", oe, 0);
    check("R1 irst", irst, 1);
    check("R1 shifts", srise | sfall, 0);
    check("R1 busy", busy_o, 0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R1 after release irst", irst, 1);

    // table walk: R3 R4 R5 R6 R8 R9 R11
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3]);
      check($sformatf("R3-R11 vec%0d held", i), held, VEC[i][2]);
      check($sformatf("R8 vec%0d oe", i), oe, VEC[i][1]);
      check($sformatf("R9 vec%0d irst", i), irst, VEC[i][0]);
    end

    // R2 exact latency of an immediate entry
    drive(1'b0, 1'b1, 1'b0);
    hold_n = 1'b0;
    repeat (LAT - 1) @(posedge clk);
    @(negedge clk);
    check("R2 before latency held", held, 0);
    @(posedge clk);
    @(negedge clk);
    check("R2 at latency held", held, 1);
    check("R2 at latency oe", oe, 0);
    hold_n = 1'b1;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    check("R2 exit latency held", held, 0);
    settle();

    // R7 shift qualifiers across a deferred entry and deferred exit
    rise_cnt = 0; fall_cnt = 0;
    for (int p = 0; p < 4; p++) begin
      drive(1'b0, 1'b1, 1'b1);
      drive(1'b0, 1'b1, 1'b0);
    end
    check("R7 running rises", rise_cnt, 4);
    check("R7 running falls", fall_cnt, 4);
    drive(1'b0, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b1);
    check("R4 pending held", held, 0);
    drive(1'b0, 1'b0, 1'b0);
    check("R4 entered held", held, 1);
    busy = 1'b1;
    for (int p = 0; p < 3; p++) begin
      drive(1'b0, 1'b0, 1'b1);
      if (p < 2) drive(1'b0, 1'b0, 1'b0);
    end
    check("R10 busy in hold", busy_o, 1);
    drive(1'b0, 1'b1, 1'b1);
    check("R5 deferred exit still held", held, 1);
    drive(1'b0, 1'b1, 1'b0);
    check("R5 deferred exit done", held, 0);
    check("R7 frozen rises", rise_cnt, 5);
    check("R7 frozen falls", fall_cnt, 4);
    for (int p = 0; p < 2; p++) begin
      drive(1'b0, 1'b1, 1'b1);
      drive(1'b0, 1'b1, 1'b0);
    end
    check("R7 resumed rises", rise_cnt, 7);
    check("R7 resumed falls", fall_cnt, 6);

    // R10 busy survives deselect during hold
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    check("R9 deselect irst", irst, 1);
    check("R10 busy through deselect", busy_o, 1);
    busy = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 busy cleared", busy_o, 0);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    check("R9 restart oe", oe, 1);
    check("R9 restart irst", irst, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule